// File: doc/BRIEF.md
# Wide-SPI Mode Entry Sequencer

This block drives the host side of a SPI link to switch an attached peripheral from plain SPI into its wide-SPI command mode. It can also send a short reset frame. A one-cycle `start` pulse launches one sequence. The `init_sel` input picks which one: the reset frame or the full mode-entry sequence. `done` pulses once when the line is idle again.

The mode-entry sequence is a 64-bit configuration frame. A preamble of two bytes of all ones comes first. Then come five body bytes: a transmit code, two zero bytes, a configuration byte and a flags byte. The configuration byte holds a fixed-busy length that is set by parameter. The frame closes with a CRC-7 byte that covers the five body bytes. After the frame, 32 extra clock periods are sent with chip select held high and the data line high, which completes mode entry. The reset frame is 64 bits of ones with no trailing clocks.

The serial clock idles low, and data changes while the clock is low. `HALF` system clocks make one half period of the serial clock.

Top module: `wspi_entry_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0 and `done` is 0.
- R2: With `init_sel`=0, the 64 bits sampled on the rising `sclk` edges while `cs_n`=0 are all ones.
- R3: With `init_sel`=1, those 64 bits are, most significant bit first, the bytes FF, FF, 40, 00, 00, C, F, K. C has bits [2:0] equal to BUSY_LEN[2:0] and bits [7:3] zero. F is 0x79, ORed with 0x80 when BUSY_LEN[2:0] is non-zero. K holds in bits [7:1] the CRC-7 of the bytes 40, 00, 00, C, F. That CRC uses polynomial x^7+x^3+1, a zero initial value and MSB-first input. Bit 0 of K is 1.
- R4: Exactly 64 rising `sclk` edges occur while `cs_n`=0 in each sequence.
- R5: With `init_sel`=1, exactly 32 rising `sclk` edges follow the frame while `cs_n`=1, each with `mosi`=1.
- R6: With `init_sel`=0, no `sclk` edge occurs while `cs_n`=1.
- R7: `cs_n` falls HALF cycles before the first rising `sclk` edge. It rises HALF cycles after the last falling edge of the frame.
- R8: `done` is high for exactly one cycle per sequence. It comes 129*HALF cycles after `cs_n` falls for the reset frame, and 193*HALF cycles after for the mode-entry sequence. While `done` is high, `cs_n`=1 and `sclk`=0.
- R9: A `start` pulse that arrives while a sequence is running is ignored. The running sequence completes unchanged, and only one `done` is produced.
- R10: `mosi` does not change while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| init_sel | input | 1 | 1: mode-entry sequence, 0: reset frame; sampled with `start` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Chip select, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check four things on every cycle: that `mosi` holds steady through each high phase of `sclk`, that every `sclk` pulse outside the frame carries `mosi` high, that `done` stays a single clean pulse on an idle bus, and that a busy sequencer does not drop back to idle on a stray `start`. Only the bench scenarios can show the bit-exact frame contents, including the CRC byte for two busy lengths. The same holds for the edge counts inside and outside chip select, and for the cycle distances between chip-select edges, clock edges and `done`.

// File: rtl/wspi_entry_seq.sv
module wspi_entry_seq #(
  parameter int HALF     = 2,
  parameter int BUSY_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic init_sel,
  output logic sclk,
  output logic mosi,
  output logic cs_n,
  output logic done
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [TW-1:0] TMAX = TW'(HALF - 1);
  localparam logic [2:0] BL = 3'(BUSY_LEN);
  localparam logic [7:0] CFG = {5'b0, BL};
  localparam logic [7:0] FLG = {(BL != 3'd0), 7'b1111001};
  localparam logic [39:0] BODY = {8'h40, 8'h00, 8'h00, CFG, FLG};

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  localparam logic [63:0] INIT_FRAME = {16'hFFFF, BODY, crc7(BODY), 1'b1};
  localparam logic [63:0] RST_FRAME  = '1;

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_HOLD, S_TAIL, S_DONE} st_t;

  st_t           st;
  logic [63:0]   sr;
  logic [5:0]    cnt;
  logic          ph;
  logic          mode;
  logic [TW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == '0);
  assign sclk = ph & ((st == S_FRAME) | (st == S_TAIL));
  assign mosi = (st == S_TAIL) ? 1'b1 : ((st == S_FRAME) | (st == S_HOLD)) ? sr[63] : 1'b0;
  assign cs_n = !((st == S_FRAME) | (st == S_HOLD));
  assign done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sr   <= '0;
      cnt  <= '0;
      ph   <= 1'b0;
      mode <= 1'b0;
      tmr  <= '0;
    end else begin
      tmr <= tick ? TMAX : tmr - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_FRAME;
          sr   <= init_sel ? INIT_FRAME : RST_FRAME;
          mode <= init_sel;
          cnt  <= '0;
          ph   <= 1'b0;
          tmr  <= TMAX;
        end
        S_FRAME: if (tick) begin
          ph <= !ph;
          if (ph) begin
            if (cnt == 6'd63) st <= S_HOLD;
            else begin
              cnt <= cnt + 1'b1;
              sr  <= {sr[62:0], 1'b0};
            end
          end
        end
        S_HOLD: if (tick) begin
          st  <= mode ? S_TAIL : S_DONE;
          cnt <= '0;
          ph  <= 1'b0;
        end
        S_TAIL: if (tick) begin
          ph <= !ph;
          if (ph) begin
            if (cnt == 6'd31) st <= S_DONE;
            else cnt <= cnt + 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)) else $error("mosi moved during sclk high"); // R10
  AST_TAIL_MOSI: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && sclk) |-> mosi) else $error("trailing clock with mosi low"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one cycle"); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !sclk)) else $error("done with bus active"); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_IDLE && st != S_DONE) |=> (st != S_IDLE)) else $error("busy sequence aborted"); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAIL) |-> (cnt <= 6'd31)) else $error("tail count overrun"); // R5
endmodule

// File: tb/sim_wspi_entry_seq.sv
`timescale 1ns/1ps
module sim_wspi_entry_seq;
  localparam int H = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0, isel = 1'b0;
  logic sclk0, mosi0, cs0, done0, sclk1, mosi1, cs1, done1;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = !clk;

  wspi_entry_seq #(.HALF(H), .BUSY_LEN(3)) u0 (.clk(clk), .rst_n(rst_n), .start(start0),
    .init_sel(isel), .sclk(sclk0), .mosi(mosi0), .cs_n(cs0), .done(done0));
  wspi_entry_seq #(.HALF(H), .BUSY_LEN(0)) u1 (.clk(clk), .rst_n(rst_n), .start(start1),
    .init_sel(isel), .sclk(sclk1), .mosi(mosi1), .cs_n(cs1), .done(done1));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit init, input int bl);
    logic [46:0] v;
    logic [7:0] cfg, flg;
    logic [39:0] body;
    if (!init) return '1;
    cfg  = 8'(bl & 7);
    flg  = 8'h79 | (((bl & 7) != 0) ? 8'h80 : 8'h00);
    body = {8'h40, 8'h00, 8'h00, cfg, flg};
    v    = {body, 7'd0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v = v ^ (47'h89 << (i - 7));
    return {16'hFFFF, body, v[6:0], 1'b1};
  endfunction

  task automatic run(input bit sel, input bit init, input int spur);
    logic [63:0] fr = '0;
    int cyc = 0, nf = 0, nt = 0, nd = 0, tfall = -1, trise = -1, tlf = -1, tcr = -1, tdone = -1, after = -1;
    bit tailbad = 0, wide = 0, hichg = 0;
    bit s, c, m, d, ps = 0, pc = 1, pd = 0, pm = 0;
    @(negedge clk);
    isel = init;
    if (sel) start1 = 1'b1; else start0 = 1'b1;
    fork
      begin
        while (after != 0 && cyc < 2000) begin
          @(negedge clk);
          start0 = 1'b0; start1 = 1'b0;
          cyc++;
          s = sel ? sclk1 : sclk0; c = sel ? cs1 : cs0;
          m = sel ? mosi1 : mosi0; d = sel ? done1 : done0;
          if (!ps && s) begin
            if (!c) begin fr = {fr[62:0], m}; nf++; if (trise < 0) trise = cyc; end
            else begin nt++; if (!m) tailbad = 1; end
          end
          if (ps && s && m != pm) hichg = 1;
          if (ps && !s && !c) tlf = cyc;
          if (pc && !c && tfall < 0) tfall = cyc;
          if (!pc && c && tcr < 0) tcr = cyc;
          if (d) begin nd++; if (pd) wide = 1; tdone = cyc; if (after < 0) after = 6; end
          if (after > 0) after--;
          ps = s; pc = c; pd = d; pm = m;
        end
      end
      begin
        if (spur > 0) begin
          repeat (spur) @(negedge clk);
          if (sel) start1 = 1'b1; else start0 = 1'b1;
        end
      end
    join
    chk(fr == exp_frame(init, sel ? 0 : 3), init ? "R3 frame (R9)" : "R2 frame (R9)", fr, exp_frame(init, sel ? 0 : 3));
    chk(nf == 64, "R4 frame edges", nf, 64);
    if (init) chk(nt == 32 && !tailbad, "R5 trailing clocks", nt, 32);
    else chk(nt == 0, "R6 no trailing clocks", nt, 0);
    chk(trise - tfall == H, "R7 cs lead", trise - tfall, H);
    chk(tcr - tlf == H, "R7 cs lag", tcr - tlf, H);
    chk(nd == 1 && !wide, "R8 done pulse (R9 single)", nd, 1);
    chk(tdone - tfall == (init ? 193 : 129) * H, "R8 done timing", tdone - tfall, (init ? 193 : 129) * H);
    chk(!hichg, "R10 mosi stable high", hichg, 0);
  endtask

  initial begin
    int seed = 32'h5A17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(cs0 && cs1 && !sclk0 && !sclk1 && !done0 && !done1, "R1 reset state", {cs0, sclk0, done0}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs0 && !sclk0 && !done0, "R1 idle after reset", {cs0, sclk0, done0}, 3'b100);
    run(0, 0, 0);
    run(0, 1, 0);
    run(1, 1, 0);
    run(1, 0, 0);
    run(0, 1, 3);
    run(0, 0, 250);
    for (int k = 0; k < 14; k++) begin
      bit sl = 1'($urandom_range(0, 1));
      bit im = 1'($urandom_range(0, 1));
      int sp = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(2, 250));
      run(sl, im, sp);
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    finished = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000 && !finished; t++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule